// File: doc/BRIEF.md
# Triggered Multi-Mode Interval Timer

This block is a down-counting interval timer for reload values of up to 16 bits. A reload value comes in on a data bus. A write-enable strobe either passes that value straight through or freezes it. A trigger input controls the count. While the trigger is high, the counter is reloaded on every clock. When the trigger is released, the count starts down, one step per clock. When the count reaches zero, the main output takes its active level. The second output, a divide-by-two output, flips on each expiry. Four output shapes are available: a level that stays or a one-clock pulse, each in normal or inverted polarity.

Mode select encoding:
- Bit 0 inverts the main output.
- Bit 1 picks a pulse instead of a held level.
- Bit 2, when set, puts the timer in an idle mode (codes 4 to 7).

The timer never reloads itself. Once it has expired, it holds at zero until the trigger is raised again. A reload value of zero leaves the timer idle.

The control state machine has five states:
- **IDLE**: not armed. Entered at reset, on a zero reload value, or in an idle mode.
- **LOADED**: the trigger is high and the counter is being reloaded.
- **COUNT**: armed and decrementing.
- **FIRE**: the expiry clock.
- **DONE**: expired and holding at zero.

The state machine has these transitions:
- **load**: any state to LOADED while the trigger is high in a timer mode.
- **arm**: LOADED to COUNT on the first clock with the trigger low, with a value of 2 or more.
- **arm-expire**: LOADED to FIRE when the value is 1.
- **reject**: LOADED to IDLE when the value is 0.
- **tick**: COUNT to COUNT.
- **expire**: COUNT to FIRE when the count steps from 1 to 0.
- **settle**: FIRE to DONE.
- **park**: any state to IDLE when an idle mode is selected.

Top module: `trig_interval_timer`

## Requirements
- R1: While `wr_en` is low, the reload value used by a load is `din` itself. While `wr_en` is high, it is the `din` value sampled at the last clock edge where `wr_en` was low.
- R2: On each rising clock edge with `trig` high in a timer mode, the counter takes the reload value and `q_out` goes to its inactive level (`mode[0]`).
- R3: With a reload value N ≥ 1, `q_out` takes its active level after exactly N rising edges. Counting of those edges starts with the first edge that samples `trig` low. Before that, `q_out` stays at its inactive level.
- R4: Mode 0: `q_out` rests low, goes high on expiry and stays high.
- R5: Mode 1: `q_out` rests high, goes low on expiry and stays low.
- R6: Mode 2: `q_out` rests low and is high for exactly one clock period on expiry.
- R7: Mode 3: `q_out` rests high and is low for exactly one clock period on expiry.
- R8: `q_half` toggles exactly once per expiry, at the edge where `q_out` takes its active level, and at no other time.
- R9: Raising `trig` while counting or after expiry aborts the count, reloads the counter and returns `q_out` to its inactive level. A full N edges are then needed after release.
- R10: A reload value of 0 never makes `q_out` active and never toggles `q_half`.
- R11: Modes 4 to 7 drive `q_out` low, ignore `trig`, keep `q_half` unchanged and drop any count in progress. Returning to a timer mode does not resume counting without a new trigger.
- R12: `rst` (active high, asynchronous) at once clears `q_half` and disarms the timer, leaving `q_out` at the inactive level of the current mode.
- R13: After expiry, the counter stays at zero and neither output changes again until `trig` is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| wr_en | input | 1 | Low: reload value follows `din`; high: value held |
| din | input | 16 | Reload value |
| trig | input | 1 | High reloads, falling release starts the count |
| mode | input | 3 | Output shape select (bit0 invert, bit1 pulse, bit2 idle) |
| q_out | output | 1 | Main timer output |
| q_half | output | 1 | Toggles on every expiry |

## Verification
The case hardest to reach from the ports is a trigger that lands in the middle of a running count. To be of use, it has to be followed by a full recount from the reloaded value rather than a resume. The bench releases the trigger and lets a count of 6 run for three edges. It then pulses the trigger and checks that the output stays inactive for five further edges and goes active on the sixth. The same approach of leaving a count in progress is used for an idle-mode switch, which must not resume, and for an asynchronous reset in mid-count.

// File: rtl/trig_tmr_pkg.sv
package trig_tmr_pkg;

    localparam int MODE_W    = 3;
    localparam int POL_BIT   = 0;
    localparam int PULSE_BIT = 1;

    typedef logic [MODE_W-1:0] tmr_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOADED = 3'd1,
        ST_COUNT  = 3'd2,
        ST_FIRE   = 3'd3,
        ST_DONE   = 3'd4
    } tmr_state_e;

    // codes 0..3 are timer modes, everything above is idle
    function automatic logic is_timer_mode(input tmr_mode_t m);
        return m < tmr_mode_t'(4);
    endfunction

endpackage

// File: rtl/trig_tmr_latch.sv
module trig_tmr_latch #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] reload_val
);

    logic [WIDTH-1:0] held;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            held <= '0;
        else if (!wr_en)
            held <= din;
    end

    // transparent while the strobe is low, frozen while high
    assign reload_val = wr_en ? held : din;

    a_r1_hold_while_high: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> $stable(held));

endmodule

// File: rtl/trig_tmr_counter.sv
module trig_tmr_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             dec,
    input  logic [WIDTH-1:0] load_val,
    output logic             at_one,
    output logic             at_zero
);

    logic [WIDTH-1:0] cnt;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec)
            cnt <= cnt - 1'b1;
    end

    assign at_zero = (cnt == '0);
    assign at_one  = (cnt == WIDTH'(1));

    a_r2_load_copies: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));

    a_r3_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (dec && !load) |=> (cnt == $past(cnt) - 1'b1));

    a_r13_no_underflow: assert property (@(posedge clk) disable iff (rst)
        dec |-> !at_zero);

    a_r13_hold_zero: assert property (@(posedge clk) disable iff (rst)
        (at_zero && !load) |=> at_zero);

endmodule

// File: rtl/trig_tmr_ctrl.sv
module trig_tmr_ctrl
    import trig_tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      trig,
    input  tmr_mode_t mode,
    input  logic      cnt_one,
    input  logic      cnt_zero,
    output logic      load,
    output logic      dec,
    output logic      q_out,
    output logic      q_half
);

    tmr_state_e state, state_nx;
    logic       mode_ok;
    logic       q_act;

    assign mode_ok = is_timer_mode(mode);

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next state and counter controls
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        dec      = 1'b0;
        if (!mode_ok) begin
            state_nx = ST_IDLE;                       // park
        end else if (trig) begin
            state_nx = ST_LOADED;                     // load
            load     = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_IDLE;
                ST_LOADED: begin
                    if (cnt_zero) begin
                        state_nx = ST_IDLE;           // reject
                    end else begin
                        dec      = 1'b1;
                        state_nx = cnt_one ? ST_FIRE : ST_COUNT;  // arm-expire / arm
                    end
                end
                ST_COUNT: begin
                    dec      = 1'b1;
                    state_nx = cnt_one ? ST_FIRE : ST_COUNT;      // expire / tick
                end
                ST_FIRE:   state_nx = ST_DONE;        // settle
                ST_DONE:   state_nx = ST_DONE;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            q_half <= 1'b0;
        else if (state_nx == ST_FIRE)
            q_half <= ~q_half;
    end

    always_comb begin
        q_act = (state == ST_FIRE) || ((state == ST_DONE) && !mode[PULSE_BIT]);
        q_out = mode_ok ? (q_act ^ mode[POL_BIT]) : 1'b0;
    end

    a_r9_trig_clears: assert property (@(posedge clk) disable iff (rst)
        (trig && mode_ok) |=> (!q_act && state == ST_LOADED));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIRE) |=> (state != ST_FIRE));

    a_r8_half_on_fire: assert property (@(posedge clk) disable iff (rst)
        !$stable(q_half) |-> (state == ST_FIRE));

    a_r10_zero_rejects: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOADED && mode_ok && !trig && cnt_zero) |=> (state == ST_IDLE));

    a_r11_idle_mode: assert property (@(posedge clk) disable iff (rst)
        !mode_ok |=> (state == ST_IDLE));

endmodule

// File: rtl/trig_interval_timer.sv
module trig_interval_timer
    import trig_tmr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  din,
    input  logic              trig,
    input  logic [MODE_W-1:0] mode,
    output logic              q_out,
    output logic              q_half
);

    logic [WIDTH-1:0] reload_val;
    logic             load, dec, at_one, at_zero;

    trig_tmr_latch #(.WIDTH(WIDTH)) u_latch (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .din        (din),
        .reload_val (reload_val)
    );

    trig_tmr_counter #(.WIDTH(WIDTH)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .dec      (dec),
        .load_val (reload_val),
        .at_one   (at_one),
        .at_zero  (at_zero)
    );

    trig_tmr_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .trig     (trig),
        .mode     (mode),
        .cnt_one  (at_one),
        .cnt_zero (at_zero),
        .load     (load),
        .dec      (dec),
        .q_out    (q_out),
        .q_half   (q_half)
    );

endmodule

// File: tb/trig_interval_timer_bench.sv
module trig_interval_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b1;
    logic [15:0] din = '0;
    logic        trig = 1'b0;
    logic [2:0]  mode = 3'd1;
    logic        q_out, q_half;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;
    logic exp_q2 = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    trig_interval_timer u_trig_interval_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .din(din),
        .trig(trig), .mode(mode), .q_out(q_out), .q_half(q_half)
    );

    // {mode[2:0], reload[15:0], rest level, pulse shape}
    localparam logic [20:0] VECS [0:5] = '{
        {3'd0, 16'd3, 1'b0, 1'b0},
        {3'd1, 16'd1, 1'b1, 1'b0},
        {3'd2, 16'd5, 1'b0, 1'b1},
        {3'd3, 16'd2, 1'b1, 1'b1},
        {3'd0, 16'd7, 1'b0, 1'b0},
        {3'd2, 16'd1, 1'b0, 1'b1}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    function automatic string shape_tag(input logic [2:0] m);
        case (m)
            3'd0:    return "R4 mode0 level";
            3'd1:    return "R5 mode1 inverted level";
            3'd2:    return "R6 mode2 pulse";
            default: return "R7 mode3 inverted pulse";
        endcase
    endfunction

    task automatic put_value(input logic [15:0] v);
        wr_en = 1'b0;
        din   = v;
        step();
        wr_en = 1'b1;
        din   = v + 16'd9;   // must be ignored while held (R1)
    endtask

    task automatic expire();
        exp_q2 = ~exp_q2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R12 reset q_out inactive (mode1)", q_out, 1'b1);
        chk("R12 reset q_half", q_half, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        step();

        // vector walk
        for (int i = 0; i < 6; i++) begin
            logic [2:0]  md;
            logic [15:0] val;
            logic        rest, pls;
            md   = VECS[i][20:18];
            val  = VECS[i][17:2];
            rest = VECS[i][1];
            pls  = VECS[i][0];
            mode = md;
            put_value(val);
            trig = 1'b1;
            step();
            step();
            chk("R2 load clears q_out", q_out, rest);
            trig = 1'b0;
            for (int k = 1; k < int'(val); k++) begin
                step();
                chk("R3 still counting", q_out, rest);
            end
            step();
            chk(shape_tag(md), q_out, ~rest);
            expire();
            chk("R8 q_half toggles on expiry", q_half, exp_q2);
            step();
            chk(shape_tag(md), q_out, pls ? rest : ~rest);
            repeat (3) step();
            chk("R13 holds after expiry", q_out, pls ? rest : ~rest);
            chk("R13 q_half stable after expiry", q_half, exp_q2);
        end

        // R13: long hold in level mode, no restart
        mode = 3'd0;
        put_value(16'd2);
        trig = 1'b1; step(); trig = 1'b0;
        step(); step();
        expire();
        repeat (20) step();
        chk("R13 level still held", q_out, 1'b1);
        chk("R13 q_half unchanged", q_half, exp_q2);

        // R9: abort in mid-count and after expiry
        trig = 1'b1; step();
        chk("R9 trig clears expired level", q_out, 1'b0);
        put_value(16'd6);
        step(); trig = 1'b0;
        repeat (3) step();
        trig = 1'b1; step();
        chk("R9 abort keeps q_out inactive", q_out, 1'b0);
        trig = 1'b0;
        repeat (5) step();
        chk("R9 full recount required", q_out, 1'b0);
        step();
        chk("R9 expiry after full recount", q_out, 1'b1);
        expire();
        chk("R9 q_half after recount", q_half, exp_q2);

        // R1: transparent path while wr_en low
        wr_en = 1'b0; din = 16'd2;
        trig = 1'b1; step(); trig = 1'b0;
        din = 16'd40;
        step();
        chk("R1 transparent value count", q_out, 1'b0);
        step();
        chk("R1 transparent value expiry", q_out, 1'b1);
        expire();
        wr_en = 1'b1;

        // R10: zero reload idles
        put_value(16'd0);
        trig = 1'b1; step(); trig = 1'b0;
        repeat (12) step();
        chk("R10 zero never asserts", q_out, 1'b0);
        chk("R10 zero keeps q_half", q_half, exp_q2);

        // R11: idle modes
        put_value(16'd4);
        trig = 1'b1; step(); trig = 1'b0;
        repeat (2) step();
        mode = 3'd6;
        step();
        chk("R11 idle mode q_out low", q_out, 1'b0);
        repeat (4) step();
        chk("R11 idle mode q_half held", q_half, exp_q2);
        mode = 3'd0;
        repeat (6) step();
        chk("R11 no resume after idle", q_out, 1'b0);
        mode = 3'd5;
        trig = 1'b1; step(); trig = 1'b0;
        mode = 3'd1;
        repeat (8) step();
        chk("R11 trig ignored in idle mode", q_out, 1'b1);
        chk("R11 q_half untouched", q_half, exp_q2);

        // R12: asynchronous reset mid-count
        put_value(16'd5);
        trig = 1'b1; step(); trig = 1'b0;
        repeat (2) step();
        #2 rst = 1'b1;
        #1;
        chk("R12 async reset q_out inactive", q_out, 1'b1);
        chk("R12 async reset q_half", q_half, 1'b0);
        exp_q2 = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        repeat (8) step();
        chk("R12 reset disarms count", q_out, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule